// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits in a receive path and decides, for every incoming frame, whether it should be kept. It watches the first twelve bytes of the frame (six destination bytes, then six source bytes), as they arrive on a byte stream. `rx_sof` marks the first byte and `rx_valid` qualifies each byte. One clock after the twelfth byte it raises a one-cycle decision strobe together with an accept flag.

A small write-only register port programs the filter. It holds the 48-bit station address as three 16-bit words, the 64-bit multicast hash table as four 16-bit words, and a control word. The control word carries three bits: promiscuous, hash enable and reject-own.

A destination is accepted in the following cases:
- it equals the station address;
- it is the broadcast address;
- it is a group address whose hash bit is set while hashing is enabled.

Reject-own drops frames that carry the station's own source address. Promiscuous mode overrides everything else.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the decision strobe and accept flag are low, and all configuration is zero: station address 00:00:00:00:00:00, hash table clear, all control bits off.
- R2: `decision_valid` is high for exactly one cycle, in the cycle after the clock edge that samples the 12th valid byte of a frame. Idle cycles (`rx_valid` low) between bytes only delay the strobe.
- R3: A frame whose destination equals the station address is accepted.
- R4: A frame whose destination is FF:FF:FF:FF:FF:FF is accepted, whatever the hash table and hash enable hold.
- R5: Multicast hash index:
  - A non-broadcast destination whose first byte has bit 0 set is looked up in the hash table.
  - The lookup uses a CRC computed over the six destination bytes. The CRC starts at 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320, takes each byte LSB first, and has no final inversion.
  - The index is CRC bits 31:26. Index bits 5:4 pick the hash word and index bits 3:0 pick the bit inside it.
  - The frame is accepted when that bit is 1. With all four words at 0xFFFF every multicast frame is accepted.
- R6: With hash enable off, a multicast destination that is not broadcast is rejected, even when the table is all ones.
- R7: A group-bit-clear destination that differs from the station address is rejected.
- R8: With promiscuous set, every frame is accepted, including frames that reject-own would drop.
- R9: With reject-own set and promiscuous clear, a frame whose source address equals the station address is rejected, even when its destination matches.
- R10: The configuration is written on a clock edge with `cfg_we` high. The address map is:
  - Addresses 0, 1 and 2 are station words. Word k holds address byte 2k in bits 15:8 and byte 2k+1 in bits 7:0; byte 0 is the first byte on the wire.
  - Addresses 3 to 6 are hash words 0 to 3.
  - Address 7 is the control word: bit 0 promiscuous, bit 1 hash enable, bit 2 reject-own.
- R11: Bytes after the 12th are ignored until the next `rx_sof`. An `rx_sof` in the middle of a frame discards the partial frame and restarts at byte 0, and the discarded frame yields no decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| rx_sof | input | 1 | Marks the first byte of a frame (valid with rx_valid) |
| rx_valid | input | 1 | Byte qualifier |
| rx_data | input | 8 | Received byte |
| decision_valid | output | 1 | One-cycle strobe: decision ready |
| decision_accept | output | 1 | 1 = keep frame, 0 = drop; held until next decision |

## Verification
The only timed result is the decision. It is due in the cycle after the edge that samples the 12th valid byte; idle gaps and extra bytes do not change this.

The driver notes the bench cycle number at which each decision is due, derived from the cycle in which it drove the last address byte. It queues the number alongside the expected accept value. The monitor samples on the falling edge and compares both the verdict and the arrival cycle. Any strobe with nothing queued is a failure, so ignored bytes and aborted frames are checked by the absence of extra strobes.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_WORDS = 4,
  parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        decision_valid,
  output logic        decision_accept
);
  localparam int STA_WORDS   = ADDR_BYTES / 2;
  localparam int FRAME_BYTES = 2 * ADDR_BYTES;
  localparam int CNT_W       = $clog2(FRAME_BYTES + 1);
  localparam int IDX_W       = $clog2(HASH_WORDS * 16);
  localparam int CTRL_ADDR   = STA_WORDS + HASH_WORDS;

  logic [15:0] sta_w  [STA_WORDS];
  logic [15:0] hash_w [HASH_WORDS];
  logic [7:0]  sta_b  [ADDR_BYTES];
  logic ctl_promisc, ctl_hash_en, ctl_rej_own;

  for (genvar g = 0; g < STA_WORDS; g++) begin : g_sta
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sta_w[g] <= '0;
      else if (cfg_we && cfg_addr == 3'(g)) sta_w[g] <= cfg_wdata;
    assign sta_b[2*g]   = sta_w[g][15:8];
    assign sta_b[2*g+1] = sta_w[g][7:0];
  end

  for (genvar h = 0; h < HASH_WORDS; h++) begin : g_hash
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) hash_w[h] <= '0;
      else if (cfg_we && cfg_addr == 3'(STA_WORDS + h)) hash_w[h] <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ctl_rej_own, ctl_hash_en, ctl_promisc} <= '0;
    else if (cfg_we && cfg_addr == 3'(CTRL_ADDR))
      {ctl_rej_own, ctl_hash_en, ctl_promisc} <= cfg_wdata[2:0];

  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++)
      c = (c >> 1) ^ ((c[0] ^ d[i]) ? CRC_POLY : 32'h0);
    return c;
  endfunction

  logic             active, dst_own, dst_bc, grp, src_own;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc;

  wire             take    = rx_valid && (rx_sof || active);
  wire [CNT_W-1:0] pos     = rx_sof ? '0 : cnt;
  wire             in_dst  = pos < CNT_W'(ADDR_BYTES);
  wire [CNT_W-1:0] apos    = in_dst ? pos : pos - CNT_W'(ADDR_BYTES);
  wire             first   = apos == '0;
  wire             last    = pos == CNT_W'(FRAME_BYTES - 1);
  wire             byte_eq = rx_data == sta_b[apos];
  wire             src_fin = src_own & byte_eq;

  wire [IDX_W-1:0] idx      = crc[31 -: IDX_W];
  wire             hash_hit = hash_w[idx[IDX_W-1:4]][idx[3:0]];
  wire             dst_pass = dst_own | dst_bc | (grp & ~dst_bc & ctl_hash_en & hash_hit);
  wire             verdict  = ctl_promisc | (~(ctl_rej_own & src_fin) & dst_pass);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; cnt <= '0; crc <= '1;
      dst_own <= 1'b0; dst_bc <= 1'b0; grp <= 1'b0; src_own <= 1'b0;
      decision_valid <= 1'b0; decision_accept <= 1'b0;
    end else begin
      decision_valid <= 1'b0;
      if (take) begin
        active <= ~last;
        cnt    <= pos + 1'b1;
        if (in_dst) begin
          dst_own <= (first | dst_own) & byte_eq;
          dst_bc  <= (first | dst_bc) & (rx_data == 8'hFF);
          crc     <= crc_byte(first ? '1 : crc, rx_data);
          if (first) grp <= rx_data[0];
        end else begin
          src_own <= (first | src_own) & byte_eq;
        end
        if (last) begin
          decision_valid  <= 1'b1;
          decision_accept <= verdict;
        end
      end
    end
  end
endmodule

module rx_addr_filter_checks (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic decision_valid,
  input logic decision_accept,
  input logic ctl_promisc
);
  always @(negedge clk)
    if (rst_n === 1'b0) p_reset_quiet_r1: assert (!decision_valid && !decision_accept);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |=> !decision_valid);

  p_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |-> $past(rx_valid));

  p_promisc_accepts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && $past(ctl_promisc)) |-> decision_accept);
endmodule

bind rx_addr_filter rx_addr_filter_checks chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
  .decision_valid(decision_valid), .decision_accept(decision_accept),
  .ctl_promisc(ctl_promisc)
);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_addr = '0; logic [15:0] cfg_wdata = '0;
  logic rx_sof = 0, rx_valid = 0; logic [7:0] rx_data = '0;
  logic decision_valid, decision_accept;

  rx_addr_filter dut_i (.*);

  always #5 clk = ~clk;

  int cyc = 0, n_checks = 0, n_fail = 0;
  bit    q_acc[$];
  int    q_due[$];
  string q_tag[$];

  logic [47:0] sh_sta = '0;
  logic [15:0] sh_hash [4] = '{default: '0};
  logic sh_pro = 0, sh_hen = 0, sh_rej = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n && decision_valid) begin
    if (q_acc.size() == 0) chk(0, "R11 stray decision", 1, 0);
    else begin
      bit a; int d; string t;
      a = q_acc.pop_front(); d = q_due.pop_front(); t = q_tag.pop_front();
      chk(decision_accept == a, {t, " accept"}, decision_accept, a);
      chk(cyc == d, "R2 timing", cyc, d);
    end
  end

  task automatic cfg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    case (a)
      3'd0: sh_sta[47:32] = d;
      3'd1: sh_sta[31:16] = d;
      3'd2: sh_sta[15:0]  = d;
      3'd7: {sh_rej, sh_hen, sh_pro} = d[2:0];
      default: sh_hash[a-3] = d;
    endcase
  endtask

  function automatic bit hash_bit(input logic [47:0] dst);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [5:0] ix;
    for (int k = 0; k < 48; k++) begin
      bit b = dst[47 - 8*(k/8) - 7 + (k%8)];
      bit fb = c[0] ^ b;
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    ix = c[31:26];
    return sh_hash[ix[5:4]][ix[3:0]];
  endfunction

  function automatic bit expect_acc(input logic [47:0] dst, input logic [47:0] src);
    bit bc = dst == 48'hFFFF_FFFF_FFFF;
    bit pass = (dst == sh_sta) || bc || (dst[40] && !bc && sh_hen && hash_bit(dst));
    return sh_pro || (!(sh_rej && src == sh_sta) && pass);
  endfunction

  task automatic frame(input logic [47:0] dst, input logic [47:0] src, input string tag,
                       input bit gaps = 0, input int extra = 0);
    logic [95:0] f = {dst, src};
    for (int k = 0; k < 12 + extra; k++) begin
      if (gaps && (k % 4 == 2)) begin @(negedge clk); rx_valid = 0; rx_sof = 0; end
      @(negedge clk);
      rx_valid = 1; rx_sof = (k == 0);
      rx_data = (k < 12) ? f[95 - 8*k -: 8] : 8'(k * 37);
      if (k == 11) begin
        q_acc.push_back(expect_acc(dst, src)); q_due.push_back(cyc + 1); q_tag.push_back(tag);
      end
    end
    @(negedge clk); rx_valid = 0; rx_sof = 0;
    repeat (3) @(negedge clk);
  endtask

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTH = 48'h0A_BB_CC_DD_EE_01;
  localparam logic [47:0] MCA = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MCB = 48'h01_00_5E_00_00_02;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    chk(decision_valid == 0, "R1 reset strobe", decision_valid, 0);
    chk(decision_accept == 0, "R1 reset accept", decision_accept, 0);
    rst_n = 1;
    frame(STA, OTH, "R1 zero config");

    cfg(0, STA[47:32]); cfg(1, STA[31:16]); cfg(2, STA[15:0]);
    frame(STA, OTH, "R3 exact");
    frame(STA, OTH, "R10 byte order R2 gaps", 1);
    frame(BC, OTH, "R4 broadcast");
    frame(OTH, STA, "R7 unicast miss");
    frame(MCA, OTH, "R6 hash off");

    cfg(7, 16'h0002);
    frame(MCA, OTH, "R5 empty table");
    begin
      logic [31:0] c = 32'hFFFF_FFFF; logic [5:0] ix;
      for (int k = 0; k < 48; k++) begin
        bit b = MCA[47 - 8*(k/8) - 7 + (k%8)];
        bit fb = c[0] ^ b;
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
      ix = c[31:26];
      cfg(3'(3 + ix[5:4]), 16'(1) << ix[3:0]);
    end
    frame(MCA, OTH, "R5 hash hit");
    frame(MCB, OTH, "R5 second group");
    for (int w = 0; w < 4; w++) cfg(3'(3 + w), 16'hFFFF);
    frame(MCB, OTH, "R5 all ones");
    cfg(7, 16'h0000);
    frame(MCB, OTH, "R6 all ones hash off");

    cfg(7, 16'h0004);
    frame(STA, STA, "R9 own source");
    frame(BC, STA, "R9 own broadcast");
    frame(STA, OTH, "R9 foreign source");
    cfg(7, 16'h0005);
    frame(STA, STA, "R8 promisc own");
    frame(OTH, OTH, "R8 promisc miss");
    cfg(7, 16'h0000);

    frame(STA, OTH, "R11 extra bytes", 0, 14);
    begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk); rx_valid = 1; rx_sof = (k == 0); rx_data = BC[47 - 8*k -: 8];
      end
    end
    frame(OTH, STA, "R11 restart");
    repeat (5) @(negedge clk);
    chk(q_acc.size() == 0, "R11 pending", q_acc.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule